// File: doc/BRIEF.md
# Boundary-Scan Test Port with User Signature

This block is a boundary-scan test access port for a programmable logic device. A four-wire serial interface (test clock, mode select, serial in, serial out) moves a controller through the standard sixteen-state graph. An instruction register selects which data register sits between the serial input and output. The data registers are a one-bit bypass stage, a 32-bit identification word, a boundary register that spans every dedicated input pin and every bidirectional pin, a 16-bit user signature, and a configuration readback word.

The controller has no separate test reset pin. A power-on reset, the active-low `rst_n`, puts it into Test-Logic-Reset. Holding the mode select high for five clocks reaches the same state from anywhere. The boundary register sits between the core and the pads. Under normal instructions, core and pad signals pass straight through. Under the external-test instruction, the pads are driven from the boundary update stages. A high-impedance instruction releases every bidirectional driver. When the security lock input is set, the configuration readback returns zeros, but the user signature can still be read.

Top module: `bscan_tap_top`

## Requirements
- R1: While `rst_n` is low and at the first clock after it rises, the controller is in Test-Logic-Reset. The active instruction is the identify code, or bypass when `ID_PRESENT` is 0. A data scan straight after reset returns `ID_VALUE`, least significant bit first.
- R2: Five consecutive rising clock edges with the mode select high put the controller in Test-Logic-Reset from any state. The active instruction then returns to its reset value.
- R3: The state graph follows the standard test-port transitions. In Capture-IR the 4-bit instruction shifter loads binary 0001, and it shifts least significant bit first. The active instruction changes only on leaving Update-IR or in Test-Logic-Reset.
- R4: The serial output and its enable change on the falling clock edge. The enable is high only while the state is Shift-IR or Shift-DR. Otherwise both the enable and the data are 0.
- R5: Opcodes are as follows: 0000 external test, 0001 sample/preload, 0010 identify, 0011 high-impedance, 0100 signature read, 0101 configuration read, 1111 bypass. Any other code acts as bypass. The bypass stage captures 0, so a scan through it returns the input delayed by one bit.
- R6: The boundary register holds `N_IN + 2*N_IO` cells, with cell 0 nearest the serial output. Cell i (i < N_IN) captures `in_pad[i]`. Cell N_IN+2k captures `io_pad_in[k]`. Cell N_IN+2k+1 captures `io_core_oe[k]`.
- R7: Under sample/preload (and every instruction other than external test and high-impedance), `io_pad_out` equals `io_core_out` and `io_pad_oe` equals `io_core_oe`. The boundary update stages load from the shifter only on leaving Update-DR while the boundary register is selected.
- R8: Under external test, `io_pad_out[k]` equals the update stage of cell N_IN+2k and `io_pad_oe[k]` equals the update stage of cell N_IN+2k+1, whatever the core drives.
- R9: Under high-impedance, every `io_pad_oe` bit is 0 and the bypass stage is the selected data register.
- R10: The signature-read instruction captures `sig_value` whatever the value of `sec_lock`.
- R11: The configuration-read instruction captures `cfg_word` when `sec_lock` is 0 and all zeros when it is 1.
- R12: `in_core` always equals `in_pad` and `io_core_in` always equals `io_pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous to tck |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Serial output driver enable |
| sig_value | input | SIG_W | User signature word |
| cfg_word | input | CFG_W | Configuration word for readback |
| sec_lock | input | 1 | Security lock, blocks configuration readback |
| in_pad | input | N_IN | Dedicated input pads |
| in_core | output | N_IN | Dedicated input values to the core |
| io_core_out | input | N_IO | Core output data for bidirectional pins |
| io_core_oe | input | N_IO | Core output enable for bidirectional pins |
| io_core_in | output | N_IO | Pad value delivered to the core |
| io_pad_in | input | N_IO | Value seen on the bidirectional pads |
| io_pad_out | output | N_IO | Data driven toward the pads |
| io_pad_oe | output | N_IO | Output enable driven toward the pads |

## Verification
The bench builds the block with N_IN=2, N_IO=3, ID_PRESENT=1, SIG_W=16 and CFG_W=8. With these values the boundary register has eight cells, which mixes both cell kinds and still keeps every scan short. With the 8-bit configuration word, the lock masking can be seen on every bit of a short scan. Random pin patterns pass through repeated preload-then-external-test rounds. Directed cases cover the five-high reset escape from mid-scan, an undefined opcode, high-impedance with every core enable set, and both lock settings for the signature and configuration reads.

// File: rtl/bscan_pkg.sv
// Shared types for the boundary-scan test port: controller states,
// instruction opcodes and the data-register selector.
package bscan_pkg;
    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    localparam int OPW = 4;
    localparam logic [OPW-1:0] OP_EXTEST = 4'h0;
    localparam logic [OPW-1:0] OP_SAMPLE = 4'h1;
    localparam logic [OPW-1:0] OP_IDCODE = 4'h2;
    localparam logic [OPW-1:0] OP_HIGHZ  = 4'h3;
    localparam logic [OPW-1:0] OP_SIGRD  = 4'h4;
    localparam logic [OPW-1:0] OP_CFGRD  = 4'h5;
    localparam logic [OPW-1:0] OP_BYPASS = 4'hF;
    localparam logic [OPW-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [2:0] { DR_BYP, DR_ID, DR_BSR, DR_SIG, DR_CFG } dr_sel_e;
endpackage

// File: rtl/bscan_tap_fsm.sv
// Test-port controller state machine.
// Assumes: tms sampled on the rising tck edge; rst_n is the power-on reset
// (there is no separate test reset pin).
module bscan_tap_fsm
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state_q
);
    tap_state_e state_d;

    // Next-state function of the standard sixteen-state graph.
    always_comb begin
        state_d = state_q;
        case (state_q)
            TS_RESET:  state_d = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   state_d = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: state_d = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: state_d = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: state_d = tms ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: state_d = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: state_d = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: state_d = tms ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: state_d = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: state_d = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: state_d = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: state_d = tms ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: state_d = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: state_d = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: state_d = tms ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: state_d = tms ? TS_SEL_DR : TS_IDLE;
            default:   state_d = TS_RESET;
        endcase
    end

    // State register with synchronous power-on reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state_q <= TS_RESET;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/bscan_ir.sv
// Instruction register: a shifter that captures a fixed pattern plus a
// parallel active-instruction stage.
// Assumes: the active stage resets to identify (or bypass without an ID word).
module bscan_ir
    import bscan_pkg::*;
#(
    parameter bit ID_PRESENT = 1'b1
) (
    input  logic           tck,
    input  logic           rst_n,
    input  tap_state_e     state_q,
    input  logic           tdi,
    output logic           ir_lsb,
    output logic [OPW-1:0] ir_q
);
    localparam logic [OPW-1:0] RST_OP = ID_PRESENT ? OP_IDCODE : OP_BYPASS;

    logic [OPW-1:0] ir_sh;

    // Instruction shifter: capture the fixed pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!rst_n)                   ir_sh <= '0;
        else if (state_q == TS_CAP_IR) ir_sh <= IR_CAPTURE;
        else if (state_q == TS_SHF_IR) ir_sh <= {tdi, ir_sh[OPW-1:1]};
    end

    // Active instruction: reset in Test-Logic-Reset, load on leaving Update-IR.
    always_ff @(posedge tck) begin
        if (!rst_n || state_q == TS_RESET) ir_q <= RST_OP;
        else if (state_q == TS_UPD_IR)     ir_q <= ir_sh;
    end

    assign ir_lsb = ir_sh[0];
endmodule

// File: rtl/bscan_shreg.sv
// Generic capture/shift data register (bypass, identification, signature,
// configuration readback). Shifts toward bit 0, serial input at the top.
module bscan_shreg #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         shf_en,
    input  logic [W-1:0] cap_val,
    input  logic         tdi,
    output logic         lsb
);
    logic [W-1:0] q;

    generate
        if (W == 1) begin : g_one
            // Single stage: capture or take the serial input directly.
            always_ff @(posedge tck) begin
                if (!rst_n)      q <= '0;
                else if (cap_en) q <= cap_val;
                else if (shf_en) q <= tdi;
            end
        end else begin : g_wide
            // Multi-stage: capture in parallel or shift one place toward bit 0.
            always_ff @(posedge tck) begin
                if (!rst_n)      q <= '0;
                else if (cap_en) q <= cap_val;
                else if (shf_en) q <= {tdi, q[W-1:1]};
            end
        end
    endgenerate

    assign lsb = q[0];
endmodule

// File: rtl/bscan_bsr.sv
// Boundary register: one capture-only cell per dedicated input, and a data
// cell plus an enable cell (each with an update stage) per bidirectional pin.
// Assumes: N_IN >= 1; cell 0 lies next to the serial output.
module bscan_bsr #(
    parameter int N_IN = 2,
    parameter int N_IO = 3
) (
    input  logic            tck,
    input  logic            rst_n,
    input  logic            sel,
    input  logic            cap,
    input  logic            shf,
    input  logic            upd,
    input  logic            tdi,
    input  logic [N_IN-1:0] in_pad,
    input  logic [N_IO-1:0] io_pad_in,
    input  logic [N_IO-1:0] io_core_oe,
    output logic            sh_lsb,
    output logic [N_IO-1:0] upd_data,
    output logic [N_IO-1:0] upd_oe
);
    localparam int L = N_IN + 2 * N_IO;

    logic [L-1:0]    cap_vec;
    logic [L-1:0]    sh_q;
    logic [N_IO-1:0] sh_data;
    logic [N_IO-1:0] sh_oe;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            assign cap_vec[i] = in_pad[i];
        end
        for (genvar k = 0; k < N_IO; k++) begin : g_io
            assign cap_vec[N_IN + 2*k]     = io_pad_in[k];
            assign cap_vec[N_IN + 2*k + 1] = io_core_oe[k];
            assign sh_data[k]              = sh_q[N_IN + 2*k];
            assign sh_oe[k]                = sh_q[N_IN + 2*k + 1];
        end
    endgenerate

    // Capture/shift stages chained from the serial input down to cell 0.
    always_ff @(posedge tck) begin
        if (!rst_n)          sh_q <= '0;
        else if (sel && cap) sh_q <= cap_vec;
        else if (sel && shf) sh_q <= {tdi, sh_q[L-1:1]};
    end

    // Update stages of the bidirectional cells, loaded on leaving Update-DR.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            upd_data <= '0;
            upd_oe   <= '0;
        end else if (sel && upd) begin
            upd_data <= sh_data;
            upd_oe   <= sh_oe;
        end
    end

    assign sh_lsb = sh_q[0];
endmodule

// File: rtl/bscan_tap_top.sv
// Boundary-scan test port top: controller, instruction decode, data
// registers, serial-output stage and the pad/core mode multiplexers.
// Assumes: rst_n is the only reset source besides the five-high escape;
// the serial output is retimed on the falling tck edge.
module bscan_tap_top
    import bscan_pkg::*;
#(
    parameter int          N_IN       = 2,
    parameter int          N_IO       = 3,
    parameter bit          ID_PRESENT = 1'b1,
    parameter logic [31:0] ID_VALUE   = 32'h0A5C_103F,
    parameter int          SIG_W      = 16,
    parameter int          CFG_W      = 8
) (
    input  logic             tck,
    input  logic             rst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic [SIG_W-1:0] sig_value,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             sec_lock,
    input  logic [N_IN-1:0]  in_pad,
    output logic [N_IN-1:0]  in_core,
    input  logic [N_IO-1:0]  io_core_out,
    input  logic [N_IO-1:0]  io_core_oe,
    output logic [N_IO-1:0]  io_core_in,
    input  logic [N_IO-1:0]  io_pad_in,
    output logic [N_IO-1:0]  io_pad_out,
    output logic [N_IO-1:0]  io_pad_oe
);
    tap_state_e      state_q;
    logic [OPW-1:0]  ir_q;
    logic            ir_lsb;
    dr_sel_e         dr_sel;
    logic            cap_dr, shf_dr, upd_dr;
    logic            byp_lsb, id_lsb, sig_lsb, cfg_lsb, bsr_lsb;
    logic [N_IO-1:0] upd_data, upd_oe;
    logic [CFG_W-1:0] cfg_cap;
    logic            tdo_next, shift_any;
    logic            mode_ext, mode_hz;

    bscan_tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state_q(state_q));

    bscan_ir #(.ID_PRESENT(ID_PRESENT)) u_ir (
        .tck(tck), .rst_n(rst_n), .state_q(state_q), .tdi(tdi),
        .ir_lsb(ir_lsb), .ir_q(ir_q)
    );

    // Instruction decode to the selected data register.
    always_comb begin
        case (ir_q)
            OP_EXTEST, OP_SAMPLE: dr_sel = DR_BSR;
            OP_IDCODE:            dr_sel = ID_PRESENT ? DR_ID : DR_BYP;
            OP_SIGRD:             dr_sel = DR_SIG;
            OP_CFGRD:             dr_sel = DR_CFG;
            default:              dr_sel = DR_BYP;
        endcase
    end

    assign cap_dr  = (state_q == TS_CAP_DR);
    assign shf_dr  = (state_q == TS_SHF_DR);
    assign upd_dr  = (state_q == TS_UPD_DR);
    assign cfg_cap = sec_lock ? '0 : cfg_word;

    bscan_shreg #(.W(1)) u_byp (
        .tck(tck), .rst_n(rst_n), .cap_en(cap_dr && dr_sel == DR_BYP),
        .shf_en(shf_dr && dr_sel == DR_BYP), .cap_val(1'b0), .tdi(tdi), .lsb(byp_lsb)
    );
    bscan_shreg #(.W(32)) u_id (
        .tck(tck), .rst_n(rst_n), .cap_en(cap_dr && dr_sel == DR_ID),
        .shf_en(shf_dr && dr_sel == DR_ID), .cap_val(ID_VALUE), .tdi(tdi), .lsb(id_lsb)
    );
    bscan_shreg #(.W(SIG_W)) u_sig (
        .tck(tck), .rst_n(rst_n), .cap_en(cap_dr && dr_sel == DR_SIG),
        .shf_en(shf_dr && dr_sel == DR_SIG), .cap_val(sig_value), .tdi(tdi), .lsb(sig_lsb)
    );
    bscan_shreg #(.W(CFG_W)) u_cfg (
        .tck(tck), .rst_n(rst_n), .cap_en(cap_dr && dr_sel == DR_CFG),
        .shf_en(shf_dr && dr_sel == DR_CFG), .cap_val(cfg_cap), .tdi(tdi), .lsb(cfg_lsb)
    );

    bscan_bsr #(.N_IN(N_IN), .N_IO(N_IO)) u_bsr (
        .tck(tck), .rst_n(rst_n), .sel(dr_sel == DR_BSR),
        .cap(cap_dr), .shf(shf_dr), .upd(upd_dr), .tdi(tdi),
        .in_pad(in_pad), .io_pad_in(io_pad_in), .io_core_oe(io_core_oe),
        .sh_lsb(bsr_lsb), .upd_data(upd_data), .upd_oe(upd_oe)
    );

    // Serial-output source: instruction shifter or the selected data register.
    always_comb begin
        shift_any = (state_q == TS_SHF_IR) || (state_q == TS_SHF_DR);
        tdo_next  = 1'b0;
        if (state_q == TS_SHF_IR) tdo_next = ir_lsb;
        else if (state_q == TS_SHF_DR) begin
            case (dr_sel)
                DR_ID:   tdo_next = id_lsb;
                DR_BSR:  tdo_next = bsr_lsb;
                DR_SIG:  tdo_next = sig_lsb;
                DR_CFG:  tdo_next = cfg_lsb;
                default: tdo_next = byp_lsb;
            endcase
        end
    end

    // Falling-edge retiming of the serial output and its enable.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= tdo_next;
            tdo_en <= shift_any;
        end
    end

    // Pad-side mode multiplexers; core-side inputs always follow the pads.
    assign mode_ext   = (ir_q == OP_EXTEST);
    assign mode_hz    = (ir_q == OP_HIGHZ);
    assign io_pad_out = mode_ext ? upd_data : io_core_out;
    assign io_pad_oe  = mode_hz ? '0 : (mode_ext ? upd_oe : io_core_oe);
    assign in_core    = in_pad;
    assign io_core_in = io_pad_in;
endmodule

// File: rtl/bscan_tap_chk.sv
// Property checker for the boundary-scan test port, bound to the top.
module bscan_tap_chk
    import bscan_pkg::*;
#(
    parameter int N_IO = 3
) (
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input logic            tdo_en,
    input tap_state_e      state_q,
    input logic [OPW-1:0]  ir_q,
    input logic [N_IO-1:0] io_pad_oe,
    input logic [N_IO-1:0] upd_data,
    input logic [N_IO-1:0] upd_oe
);
    logic [2:0] hi_cnt;

    // Count consecutive mode-select-high edges, saturating at five.
    always_ff @(posedge tck) begin
        if (!rst_n || !tms)   hi_cnt <= '0;
        else if (hi_cnt != 5) hi_cnt <= hi_cnt + 3'd1;
    end

    a_r1_reset_tlr: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(rst_n) |-> state_q == TS_RESET);
    a_r2_five_high: assert property (@(posedge tck) disable iff (!rst_n)
        (hi_cnt == 3'd5) |-> state_q == TS_RESET);
    a_r3_ir_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q != TS_UPD_IR && state_q != TS_RESET) |=> $stable(ir_q));
    a_r4_tdo_en_shift: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en |-> (state_q == TS_SHF_DR || state_q == TS_SHF_IR));
    a_r7_update_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (state_q != TS_UPD_DR) |=> ($stable(upd_data) && $stable(upd_oe)));
    a_r9_highz_oe: assert property (@(posedge tck) disable iff (!rst_n)
        (ir_q == OP_HIGHZ) |-> (io_pad_oe == '0));
endmodule

bind bscan_tap_top bscan_tap_chk #(.N_IO(N_IO)) chk_i (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdo_en(tdo_en),
    .state_q(state_q), .ir_q(ir_q), .io_pad_oe(io_pad_oe),
    .upd_data(upd_data), .upd_oe(upd_oe)
);

// File: tb/bscan_tap_top_tb.sv
`timescale 1ns/1ps
module bscan_tap_top_tb_top;
    localparam int N_IN = 2, N_IO = 3, SIG_W = 16, CFG_W = 8;
    localparam int L = N_IN + 2 * N_IO;
    localparam logic [31:0] IDV = 32'h0A5C_103F;

    logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, sec_lock = 1'b0;
    logic [SIG_W-1:0] sig_value = 16'hC3A5;
    logic [CFG_W-1:0] cfg_word = 8'h96;
    logic [N_IN-1:0] in_pad = '0, in_core;
    logic [N_IO-1:0] io_core_out = '0, io_core_oe = '0, io_pad_in = '0;
    logic [N_IO-1:0] io_core_in, io_pad_out, io_pad_oe;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #2.5 tck = ~tck;

    bscan_tap_top #(.N_IN(N_IN), .N_IO(N_IO), .ID_PRESENT(1'b1), .ID_VALUE(IDV),
                    .SIG_W(SIG_W), .CFG_W(CFG_W)) dut_i (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .sig_value(sig_value), .cfg_word(cfg_word), .sec_lock(sec_lock),
        .in_pad(in_pad), .in_core(in_core), .io_core_out(io_core_out),
        .io_core_oe(io_core_oe), .io_core_in(io_core_in), .io_pad_in(io_pad_in),
        .io_pad_out(io_pad_out), .io_pad_oe(io_pad_oe));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive inputs, pass the rising edge, settle after the falling edge.
    task automatic step(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #0.5;
    endtask

    // From Run-Test/Idle: load an opcode, return the captured IR bits, end in idle.
    task automatic shift_ir(input logic [3:0] op, output logic [3:0] got);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin got[i] = tdo; step(i == 3, op[i]); end
        step(1, 0); step(0, 0);
    endtask

    // From Run-Test/Idle: scan n bits of data, return what came out, end in idle.
    task automatic shift_dr(input logic [63:0] d, input int n, output logic [63:0] got);
        got = '0;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin got[i] = tdo; step(i == n - 1, d[i]); end
        step(1, 0); step(0, 0);
    endtask

    // Expected boundary capture from the current pin values (R6 layout).
    function automatic logic [63:0] exp_cap();
        logic [63:0] v = '0;
        for (int i = 0; i < N_IN; i++) v[i] = in_pad[i];
        for (int k = 0; k < N_IO; k++) begin
            v[N_IN + 2*k]     = io_pad_in[k];
            v[N_IN + 2*k + 1] = io_core_oe[k];
        end
        return v;
    endfunction

    function automatic logic [N_IO-1:0] pick(input logic [63:0] v, input int off);
        logic [N_IO-1:0] r;
        for (int k = 0; k < N_IO; k++) r[k] = v[N_IN + 2*k + off];
        return r;
    endfunction

    function automatic logic [63:0] byp_exp(input logic [63:0] d, input int n);
        logic [63:0] r = '0;
        for (int i = 1; i < n; i++) r[i] = d[i-1];
        return r;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [3:0] g4;
        logic [63:0] got, d;
        void'($urandom(32'h00C0FFEE));
        in_pad = 2'b10; io_pad_in = 3'b011; io_core_out = 3'b101; io_core_oe = 3'b110;
        repeat (4) @(negedge tck);
        #0.5; rst_n = 1'b1;
        check("R4 enable low after reset", tdo_en, 0);
        check("R12 core inputs follow pads", {in_core, io_core_in}, {in_pad, io_pad_in});
        check("R7 pass-through after reset", {io_pad_out, io_pad_oe}, {io_core_out, io_core_oe});
        step(0, 0);
        check("R4 enable low in idle", {tdo_en, tdo}, 0);
        shift_dr(64'h0, 32, got);
        check("R1 identify word after reset", got[31:0], IDV);

        shift_ir(4'h1, g4);
        check("R3 IR capture pattern", g4, 4'b0001);
        for (int it = 0; it < 6; it++) begin
            logic [63:0] pre;
            in_pad = N_IN'($urandom); io_pad_in = N_IO'($urandom);
            io_core_out = N_IO'($urandom); io_core_oe = N_IO'($urandom);
            pre = 64'($urandom) & ((64'd1 << L) - 1);
            shift_ir(4'h1, g4);
            shift_dr(pre, L, got);
            check("R6 boundary capture under sample", got, exp_cap());
            check("R7 pads untouched by sample", {io_pad_out, io_pad_oe}, {io_core_out, io_core_oe});
            check("R12 core inputs under sample", {in_core, io_core_in}, {in_pad, io_pad_in});
            shift_ir(4'h0, g4);
            io_core_out = ~io_core_out; io_core_oe = ~io_core_oe;
            check("R8 extest drives preloaded data", io_pad_out, pick(pre, 0));
            check("R8 extest drives preloaded enable", io_pad_oe, pick(pre, 1));
            shift_dr(pre, L, got);
            check("R6 boundary capture under extest", got, exp_cap());
            check("R8 second update", {io_pad_out, io_pad_oe}, {pick(pre, 0), pick(pre, 1)});
            shift_ir(4'hF, g4);
        end

        io_core_oe = '1;
        shift_ir(4'h3, g4);
        check("R9 highz releases drivers", io_pad_oe, 0);
        d = 64'h15;
        shift_dr(d, 5, got);
        check("R9 highz selects bypass", got[4:0], byp_exp(d, 5));
        shift_ir(4'hF, g4);
        check("R7 pass-through after highz", io_pad_oe, io_core_oe);
        d = 64'h2D;
        shift_dr(d, 6, got);
        check("R5 bypass one-bit delay", got[5:0], byp_exp(d, 6));
        shift_ir(4'hA, g4);
        d = 64'h1B;
        shift_dr(d, 6, got);
        check("R5 undefined opcode acts as bypass", got[5:0], byp_exp(d, 6));

        shift_ir(4'h4, g4);
        shift_dr(64'h0, SIG_W, got);
        check("R10 signature unlocked", got[SIG_W-1:0], sig_value);
        sec_lock = 1'b1;
        shift_dr(64'h0, SIG_W, got);
        check("R10 signature with lock", got[SIG_W-1:0], sig_value);
        shift_ir(4'h5, g4);
        shift_dr(64'h0, CFG_W, got);
        check("R11 config blocked by lock", got[CFG_W-1:0], 0);
        sec_lock = 1'b0;
        shift_dr(64'h0, CFG_W, got);
        check("R11 config readable unlocked", got[CFG_W-1:0], cfg_word);

        shift_ir(4'hF, g4);
        step(1, 0); step(0, 0); step(0, 0);
        check("R4 enable high in shift", tdo_en, 1);
        step(0, 1); step(0, 0);
        repeat (5) step(1, 0);
        step(0, 0);
        check("R4 enable low after escape", tdo_en, 0);
        shift_dr(64'h0, 32, got);
        check("R2 five-high escape restores identify", got[31:0], IDV);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule